// File: doc/BRIEF.md
# Guest Preemption Countdown Timer

This block counts down a time budget for a guest. The budget is granted when the guest is entered. When the entry strobe arrives and the activate control is set, the timer takes an unsigned 32-bit start value. It then counts down by one on each rate tick. When it reaches zero, it raises an expiry request toward the event priority arbiter. The tick divider lives outside the block, and so does saving the count when the guest exits.

A start value of zero counts as expired within the entry itself, without waiting for a tick. The request is always held back until the injection-done signal reports that event injection for this entry has finished. As a result, it can only win arbitration before the first guest instruction. An entry into the wait-for-startup activity state records any expiry but never produces a request. Once raised, the request stays high until the arbiter acknowledges it. A fresh entry reloads the timer and drops any request left over from before.

Top module: `gpt_timer`

## Requirements
- R1: After reset, `count_o` is 0 and `expiry_req_o` is 0.
- R2: An entry strobe with `arm_i`=1 loads `start_i` as an unsigned value, and `count_o` shows it after that clock edge. The full range up to all ones is accepted.
- R3: While armed and nonzero, the count drops by exactly one on each clock edge where `tick_i` is 1. Without a tick it holds.
- R4: The count stops at zero and never wraps, whatever further ticks arrive.
- R5: An armed entry with a start value of 0 is expired at once, with no tick. `expiry_req_o` rises on the first clock edge after injection-done has been sampled, and never while the count is nonzero.
- R6: `expiry_req_o` stays low after an armed entry until `inj_done_i` has been sampled high. The count still runs during this wait.
- R7: If the entry's `guest_state_i` is wait-for-startup (code 2'b11), no expiry request is raised for that entry, even when the count reaches zero. The other codes (0 active, 1 halted, 2 shutdown) do not suppress the request.
- R8: Once high, `expiry_req_o` stays high until `expiry_ack_i` is sampled high. It is low from the following edge.
- R9: Any entry strobe clears a pending `expiry_req_o` on that edge. An armed entry also reloads the count.
- R10: An entry with `arm_i`=0 leaves the count frozen at its previous value. Ticks then have no effect, and no expiry request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| entry_i | input | 1 | One-cycle strobe marking a guest entry |
| arm_i | input | 1 | Activate control, sampled with the entry strobe |
| start_i | input | 32 | Unsigned start value, sampled with the entry strobe |
| guest_state_i | input | 2 | Activity state entered: 0 active, 1 halted, 2 shutdown, 3 wait-for-startup |
| tick_i | input | 1 | Rate tick, one decrement per high cycle |
| inj_done_i | input | 1 | Event injection for the current entry has completed |
| expiry_ack_i | input | 1 | Arbiter acknowledge of the expiry request |
| count_o | output | 32 | Current count |
| expiry_req_o | output | 1 | Expiry request toward the priority arbiter |

## Verification
The bench sets up an entry with a zero start value and holds injection-done back for several cycles. A design that raised the request during the entry, or waited for a tick, would show up here as an early or missing request. It checks the cycle on which the request rises after injection. It counts down the all-ones start value, which would fail in any design that treats the value as signed or narrow. It ticks past zero to catch a count that wraps. It repeats the zero-start case with the wait-for-startup state, where a leaked request is a failure. It strobes entries with the activate control off to show a frozen count. Finally, it re-enters while a request is pending: a stale request that survives this re-entry would be reported.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    ACT_RUN          = 2'd0,
    ACT_HALT         = 2'd1,
    ACT_SHUTDOWN     = 2'd2,
    ACT_WAIT_STARTUP = 2'd3
  } act_state_e;

  localparam int unsigned ACT_W = 2;

  function automatic logic is_wait_startup(input logic [ACT_W-1:0] st);
    return st == ACT_WAIT_STARTUP;
  endfunction

endpackage

// File: rtl/gpt_rst_sync.sv
module gpt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         arm_i,
  input  logic [W-1:0] start_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    cnt_en = 1'b0;
    if (load_i) begin
      run_d = arm_i;
      if (arm_i) begin
        cnt_d  = start_i;
        cnt_en = 1'b1;
      end
    end else if (run_q && tick_i && (cnt_q != '0)) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  // Expiry event: zero start at entry, or the last tick reaching zero.
  assign expire_o = (load_i && arm_i && (start_i == '0)) ||
                    (!load_i && run_q && tick_i && (cnt_q == ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_i && !load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - ONE));

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (cnt_q == '0)) |=> (cnt_q == '0));

  assert_frozen_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/gpt_req_gate.sv
module gpt_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic arm_i,
  input  logic wfs_i,
  input  logic expire_i,
  input  logic inj_done_i,
  input  logic ack_i,
  output logic req_o
);

  logic wait_q, wait_d;
  logic mute_q, mute_d;
  logic hit_q,  hit_d;
  logic req_q,  req_d;

  always_comb begin
    wait_d = wait_q;
    mute_d = mute_q;
    hit_d  = hit_q;
    req_d  = req_q;
    if (load_i) begin
      wait_d = arm_i;
      mute_d = arm_i && wfs_i;
      hit_d  = expire_i;
      req_d  = 1'b0;
    end else begin
      if (inj_done_i) wait_d = 1'b0;
      if (expire_i)   hit_d  = 1'b1;
      if (ack_i)      req_d  = 1'b0;
      if (hit_q && !wait_q) begin
        hit_d = expire_i;
        if (!mute_q) req_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      mute_q <= 1'b0;
      hit_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      wait_q <= wait_d;
      mute_q <= mute_d;
      hit_q  <= hit_d;
      req_q  <= req_d;
    end
  end

  assign req_o = req_q;

  assert_held_for_injection_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(!wait_q));

  assert_startup_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mute_q |-> !req_q);

  assert_sticky_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i && !load_i) |=> req_q);

  assert_entry_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !req_q);

endmodule

// File: rtl/gpt_timer.sv
module gpt_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [1:0]       guest_state_i,
  input  logic             tick_i,
  input  logic             inj_done_i,
  input  logic             expiry_ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expiry_req_o
);

  import gpt_pkg::*;

  logic rst_int_n;
  logic expire;
  logic wfs;

  assign wfs = is_wait_startup(guest_state_i);

  gpt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  gpt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (entry_i),
    .arm_i    (arm_i),
    .start_i  (start_i),
    .tick_i   (tick_i),
    .cnt_o    (count_o),
    .expire_o (expire)
  );

  gpt_req_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (entry_i),
    .arm_i      (arm_i),
    .wfs_i      (wfs),
    .expire_i   (expire),
    .inj_done_i (inj_done_i),
    .ack_i      (expiry_ack_i),
    .req_o      (expiry_req_o)
  );

  assert_req_only_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(expiry_req_o) |-> (count_o == '0));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_int_n |-> (!expiry_req_o && (count_o == '0)));

endmodule

// File: tb/tb_gpt_timer.sv
module tb_gpt_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        entry_i, arm_i, tick_i, inj_done_i, expiry_ack_i;
  logic [31:0] start_i;
  logic [1:0]  guest_state_i;
  logic [31:0] count_o;
  logic        expiry_req_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gpt_timer dut (
    .clk(clk), .rst_n(rst_n), .entry_i(entry_i), .arm_i(arm_i),
    .start_i(start_i), .guest_state_i(guest_state_i), .tick_i(tick_i),
    .inj_done_i(inj_done_i), .expiry_ack_i(expiry_ack_i),
    .count_o(count_o), .expiry_req_o(expiry_req_o)
  );

  // {start, ticks, expected count}
  localparam logic [71:0] VEC [6] = '{
    {32'd5,          8'd3, 32'd2},
    {32'd3,          8'd3, 32'd0},
    {32'd2,          8'd5, 32'd0},
    {32'hFFFF_FFFF,  8'd2, 32'hFFFF_FFFD},
    {32'd1,          8'd0, 32'd1},
    {32'h8000_0000,  8'd1, 32'h7FFF_FFFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(input logic arm, input logic [31:0] sv, input logic [1:0] st);
    @(negedge clk);
    entry_i = 1'b1; arm_i = arm; start_i = sv; guest_state_i = st;
    @(negedge clk);
    entry_i = 1'b0;
  endtask

  task automatic inject;
    @(negedge clk); inj_done_i = 1'b1;
    @(negedge clk); inj_done_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic ack;
    @(negedge clk); expiry_ack_i = 1'b1;
    @(negedge clk); expiry_ack_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; entry_i = 0; arm_i = 0; tick_i = 0; inj_done_i = 0;
    expiry_ack_i = 0; start_i = '0; guest_state_i = 2'd0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    chk("R1 count after reset", count_o, 32'd0);
    chk("R1 req after reset", {31'd0, expiry_req_o}, 32'd0);

    // Table walk: load, inject, tick, compare.
    for (int i = 0; i < 6; i++) begin
      enter(1'b1, VEC[i][71:40], 2'd0);
      chk("R2 loaded value", count_o, VEC[i][71:40]);
      inject();
      ticks(int'(VEC[i][39:32]));
      idle(2);
      chk("R3 R4 count after ticks", count_o, VEC[i][31:0]);
      chk("R5 req matches zero", {31'd0, expiry_req_o}, {31'd0, VEC[i][31:0] == 32'd0});
      if (VEC[i][31:0] == 32'd0) begin
        ack();
        chk("R8 req cleared by ack", {31'd0, expiry_req_o}, 32'd0);
      end
    end

    // Zero start: expired at entry, held until injection.
    enter(1'b1, 32'd0, 2'd0);
    idle(3);
    chk("R6 req held before injection", {31'd0, expiry_req_o}, 32'd0);
    chk("R5 zero start count", count_o, 32'd0);
    inject();
    chk("R5 req one edge later not yet", {31'd0, expiry_req_o}, 32'd0);
    idle(1);
    chk("R5 req after injection", {31'd0, expiry_req_o}, 32'd1);
    idle(5);
    chk("R8 req sticky", {31'd0, expiry_req_o}, 32'd1);

    // Re-entry clears stale request and reloads.
    enter(1'b1, 32'd10, 2'd1);
    chk("R9 stale req cleared", {31'd0, expiry_req_o}, 32'd0);
    chk("R9 reload", count_o, 32'd10);
    idle(4);
    chk("R3 no tick holds", count_o, 32'd10);

    // Inactive entry: frozen.
    enter(1'b0, 32'd77, 2'd0);
    chk("R10 count frozen at entry", count_o, 32'd10);
    inject();
    ticks(3);
    idle(2);
    chk("R10 ticks ignored", count_o, 32'd10);
    chk("R10 no req", {31'd0, expiry_req_o}, 32'd0);

    // Inactive entry also drops a pending request.
    enter(1'b1, 32'd0, 2'd0);
    inject(); idle(2);
    chk("R5 req raised again", {31'd0, expiry_req_o}, 32'd1);
    enter(1'b0, 32'd5, 2'd0);
    chk("R9 inactive entry clears req", {31'd0, expiry_req_o}, 32'd0);
    idle(3);
    chk("R10 no req later", {31'd0, expiry_req_o}, 32'd0);

    // Count runs while injection pending; request waits.
    enter(1'b1, 32'd2, 2'd0);
    ticks(2);
    idle(2);
    chk("R6 count ran during wait", count_o, 32'd0);
    chk("R6 req still held", {31'd0, expiry_req_o}, 32'd0);
    inject(); idle(1);
    chk("R6 req after late injection", {31'd0, expiry_req_o}, 32'd1);

    // Wait-for-startup entries never request.
    enter(1'b1, 32'd0, 2'd3);
    inject(); idle(4);
    chk("R7 zero start silent", {31'd0, expiry_req_o}, 32'd0);
    enter(1'b1, 32'd2, 2'd3);
    inject(); ticks(4); idle(3);
    chk("R7 count reached zero", count_o, 32'd0);
    chk("R7 countdown silent", {31'd0, expiry_req_o}, 32'd0);

    // Shutdown state does not suppress.
    enter(1'b1, 32'd0, 2'd2);
    inject(); idle(2);
    chk("R7 shutdown still requests", {31'd0, expiry_req_o}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule